// File: doc/BRIEF.md
# Serial Port Control Register Sequencer

This block is the processor-side control logic of a byte-oriented serial port. It has one address line and a byte-wide write bus. Writes to the control address go through a small sequencer. The first write after a reset, or after a software reset command, is a mode byte. Depending on that byte, zero, one or two synchronisation characters follow it. After that, every control write is a command byte. The block decodes each command into the modem control outputs and the receiver and transmitter enables. It also turns some command bits into one-cycle pulses that clear the error flags or restart the port.

The block assembles an 8-bit status word from three sources: level flags from the transmit and receive paths, sticky error flags that it sets from one-cycle pulses, and a synchronised copy of the external data-set-ready pin. While the transmitter is disabled, the transmit flags in the status word read as zero. Writes to the data address belong to the data path and do not touch this block. The captured mode byte and sync characters are brought out for the serial engines.

Top module: `usart_ctrl_seq`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, the outputs hold these values: `async_o`=0, `sync_o`=0, `dtr_o`=0, `rts_o`=0, `tx_en_o`=1, `rx_en_o`=1, `err_clr_o`=0 and `soft_rst_o`=0. Status bits 0 and 2 read 1 and status bits 1 and 3 to 6 read 0, whatever the flag inputs are.
- R2: In the cleared state (`async_o`=0 and `sync_o`=0, with no sync character pending), a control write (`wr_en`=1, `addr`=1) whose bits [1:0] are not zero enters the asynchronous run state (`async_o`=1) at the next edge, and `mode_o` captures the byte.
- R3: A cleared-state control write with bits [1:0]=0 and bit 7=1 expects one sync character. The next control write is stored on `sync_last_o`, and the block then enters the synchronous run state (`sync_o`=1).
- R4: A cleared-state control write with bits [1:0]=0 and bit 7=0 expects two sync characters. The first is stored on `sync_first_o` and leaves `sync_o` low. The second is stored on `sync_last_o` and sets `sync_o`.
- R5: In either run state, a control write with bit 6 clear is a command. At the next edge, bit 0 sets `tx_en_o`, bit 1 sets `dtr_o`, bit 2 sets `rx_en_o` and bit 3 sets `rts_o`.
- R6: A command with bit 4 set raises `err_clr_o` for one cycle and clears the status error bits 3 (parity), 4 (overrun) and 5 (framing). If an error set pulse arrives in the same cycle as the clear, that flag stays set.
- R7: A run-state control write with bit 6 set returns the block to the cleared state and raises `soft_rst_o` for one cycle. The other bits of that byte have no effect on `dtr_o`, `rts_o`, the enables or `err_clr_o`.
- R8: A control write in the cleared state or while a sync character is pending is not treated as a command and leaves `dtr_o`, `rts_o`, `tx_en_o`, `rx_en_o` and `err_clr_o` unchanged. A write to the data address (`addr`=0) changes no output.
- R9: The status word is laid out as follows: bit 0 transmitter ready, bit 1 receiver ready, bit 2 transmitter empty, bit 3 parity error, bit 4 overrun error, bit 5 framing error, bit 6 sync detect, bit 7 data set ready. The level flags show their input one edge later. The error bits are set by their one-cycle pulses and stay set until they are cleared.
- R10: While `tx_en_o` is 0, status bits 0 and 2 read 0 whatever the transmit flags are.
- R11: Status bit 7 follows `dsr_i` after `SYNC_STAGES` clock edges (2 by default), and it keeps doing so while reset is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| addr | input | 1 | 1 selects control, 0 selects data |
| wdata | input | 8 | Write data byte |
| tx_rdy_i | input | 1 | Transmit path can accept a byte |
| tx_empty_i | input | 1 | Transmit path fully drained |
| rx_rdy_i | input | 1 | Receive path holds a byte |
| syn_det_i | input | 1 | Sync or break detected |
| pe_set_i | input | 1 | Parity error pulse |
| oe_set_i | input | 1 | Overrun error pulse |
| fe_set_i | input | 1 | Framing error pulse |
| dsr_i | input | 1 | Asynchronous data-set-ready pin |
| status_o | output | 8 | Assembled status word |
| dtr_o | output | 1 | Data terminal ready |
| rts_o | output | 1 | Request to send / break |
| tx_en_o | output | 1 | Transmitter enable |
| rx_en_o | output | 1 | Receiver enable |
| err_clr_o | output | 1 | One-cycle error clear pulse |
| soft_rst_o | output | 1 | One-cycle software reset pulse |
| async_o | output | 1 | Asynchronous run state |
| sync_o | output | 1 | Synchronous run state |
| mode_o | output | 8 | Captured mode byte |
| sync_first_o | output | 8 | First sync character (two-character mode) |
| sync_last_o | output | 8 | Final sync character |

## Verification
When the sequencer state is wrong, the bytes that follow are misinterpreted. A byte meant as a sync character then changes `dtr_o` or the enables, or a real command is swallowed. Either fault shows at the port one edge after the offending write. The tests therefore write sequences that are harmless in the correct state but visible in a wrong one, and they check on the very next cycle. Faults in the error flags or the transmit mask show in `status_o` one edge after the pulse or command that caused them. Counting the cycles it takes the synchroniser to reach bit 7 catches a wrong number of stages.

// File: rtl/usart_seq_pkg.sv
package usart_seq_pkg;

    typedef enum logic [2:0] {
        ST_CLEARED    = 3'd0,
        ST_ASYNC      = 3'd1,
        ST_SYNC       = 3'd2,
        ST_HUNT_LAST  = 3'd3,
        ST_HUNT_FIRST = 3'd4
    } ctl_state_e;

    // command byte fields
    localparam int CMD_TXEN = 0;
    localparam int CMD_DTR  = 1;
    localparam int CMD_RXEN = 2;
    localparam int CMD_RTS  = 3;
    localparam int CMD_ECLR = 4;
    localparam int CMD_SPARE = 5;
    localparam int CMD_SRST = 6;
    localparam int CMD_TOP  = 7;

    // mode byte fields
    localparam int MODE_ASYNC_LO = 0;
    localparam int MODE_ASYNC_HI = 1;
    localparam int MODE_ONE_SYNC = 7;

    // status word positions
    localparam int STAT_W     = 8;
    localparam int ST_TXRDY   = 0;
    localparam int ST_RXRDY   = 1;
    localparam int ST_TXEMPTY = 2;
    localparam int ST_PERR    = 3;
    localparam int ST_OERR    = 4;
    localparam int ST_FERR    = 5;
    localparam int ST_SYNDET  = 6;
    localparam int ST_DSR     = 7;

endpackage

// File: rtl/usart_mode_fsm.sv
module usart_mode_fsm
    import usart_seq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              cmd_valid,
    output logic              async_o,
    output logic              sync_o,
    output logic [DATA_W-1:0] mode_o,
    output logic [DATA_W-1:0] sync_first_o,
    output logic [DATA_W-1:0] sync_last_o
);

    typedef struct packed {
        ctl_state_e        state;
        logic [DATA_W-1:0] mode;
        logic [DATA_W-1:0] s_first;
        logic [DATA_W-1:0] s_last;
    } fsm_regs_t;

    fsm_regs_t fsm_d, fsm_q;
    logic      cmd_valid_d;

    always_comb begin
        fsm_d       = fsm_q;
        cmd_valid_d = 1'b0;
        unique case (fsm_q.state)
            ST_CLEARED: begin
                if (ctl_wr) begin
                    fsm_d.mode = wdata;
                    if (wdata[MODE_ASYNC_HI] || wdata[MODE_ASYNC_LO]) begin
                        fsm_d.state = ST_ASYNC;
                    end else if (wdata[MODE_ONE_SYNC]) begin
                        fsm_d.state = ST_HUNT_LAST;
                    end else begin
                        fsm_d.state = ST_HUNT_FIRST;
                    end
                end
            end
            ST_HUNT_FIRST: begin
                if (ctl_wr) begin
                    fsm_d.s_first = wdata;
                    fsm_d.state   = ST_HUNT_LAST;
                end
            end
            ST_HUNT_LAST: begin
                if (ctl_wr) begin
                    fsm_d.s_last = wdata;
                    fsm_d.state  = ST_SYNC;
                end
            end
            ST_ASYNC, ST_SYNC: begin
                if (ctl_wr) begin
                    cmd_valid_d = 1'b1;
                    if (wdata[CMD_SRST]) begin
                        fsm_d.state = ST_CLEARED;
                    end
                end
            end
            default: fsm_d.state = ST_CLEARED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm_q.state <= ST_CLEARED;
            fsm_q.mode    <= '0;
            fsm_q.s_first <= '0;
            fsm_q.s_last  <= '0;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign cmd_valid    = cmd_valid_d;
    assign async_o      = (fsm_q.state == ST_ASYNC);
    assign sync_o       = (fsm_q.state == ST_SYNC);
    assign mode_o       = fsm_q.mode;
    assign sync_first_o = fsm_q.s_first;
    assign sync_last_o  = fsm_q.s_last;

endmodule

// File: rtl/usart_cmd_regs.sv
module usart_cmd_regs
    import usart_seq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [DATA_W-1:0] wdata,
    output logic              clr_req,
    output logic              tx_en_o,
    output logic              rx_en_o,
    output logic              dtr_o,
    output logic              rts_o,
    output logic              err_clr_o,
    output logic              soft_rst_o
);

    typedef struct packed {
        logic tx_en;
        logic rx_en;
        logic dtr;
        logic rts;
        logic err_clr;
        logic soft_rst;
    } cmd_regs_t;

    cmd_regs_t cmd_d, cmd_q;
    logic      is_cmd;
    logic      unused_cmd_bits;

    assign is_cmd          = cmd_valid && !wdata[CMD_SRST];
    assign unused_cmd_bits = ^{wdata[CMD_SPARE], wdata[DATA_W-1:CMD_TOP]};

    always_comb begin
        cmd_d          = cmd_q;
        cmd_d.err_clr  = 1'b0;
        cmd_d.soft_rst = 1'b0;
        if (cmd_valid && wdata[CMD_SRST]) begin
            cmd_d.soft_rst = 1'b1;
        end else if (is_cmd) begin
            cmd_d.tx_en   = wdata[CMD_TXEN];
            cmd_d.rx_en   = wdata[CMD_RXEN];
            cmd_d.dtr     = wdata[CMD_DTR];
            cmd_d.rts     = wdata[CMD_RTS];
            cmd_d.err_clr = wdata[CMD_ECLR];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '{tx_en: 1'b1, rx_en: 1'b1, dtr: 1'b0, rts: 1'b0,
                       err_clr: 1'b0, soft_rst: 1'b0};
        end else begin
            cmd_q <= cmd_d;
        end
    end

    assign clr_req    = is_cmd && wdata[CMD_ECLR];
    assign tx_en_o    = cmd_q.tx_en;
    assign rx_en_o    = cmd_q.rx_en;
    assign dtr_o      = cmd_q.dtr;
    assign rts_o      = cmd_q.rts;
    assign err_clr_o  = cmd_q.err_clr;
    assign soft_rst_o = cmd_q.soft_rst;

endmodule

// File: rtl/usart_status_asm.sv
module usart_status_asm
    import usart_seq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_rdy_i,
    input  logic              tx_empty_i,
    input  logic              rx_rdy_i,
    input  logic              syn_det_i,
    input  logic              pe_set_i,
    input  logic              oe_set_i,
    input  logic              fe_set_i,
    input  logic              clr_req,
    input  logic              tx_en,
    input  logic              dsr_i,
    output logic [STAT_W-1:0] status_o
);

    typedef struct packed {
        logic tx_rdy;
        logic tx_empty;
        logic rx_rdy;
        logic syn_det;
        logic pe;
        logic oe;
        logic fe;
    } flag_regs_t;

    flag_regs_t flg_d, flg_q;
    logic [SYNC_STAGES-1:0] dsr_sync_q;
    logic                   dsr_s;

    // synchroniser has no reset so the pin state survives a port reset
    generate
        if (SYNC_STAGES == 1) begin : g_sync_one
            always_ff @(posedge clk) dsr_sync_q <= dsr_i;
        end else begin : g_sync_chain
            always_ff @(posedge clk) dsr_sync_q <= {dsr_sync_q[SYNC_STAGES-2:0], dsr_i};
        end
    endgenerate
    assign dsr_s = dsr_sync_q[SYNC_STAGES-1];

    always_comb begin
        flg_d          = flg_q;
        flg_d.tx_rdy   = tx_rdy_i;
        flg_d.tx_empty = tx_empty_i;
        flg_d.rx_rdy   = rx_rdy_i;
        flg_d.syn_det  = syn_det_i;
        flg_d.pe       = (flg_q.pe && !clr_req) || pe_set_i;
        flg_d.oe       = (flg_q.oe && !clr_req) || oe_set_i;
        flg_d.fe       = (flg_q.fe && !clr_req) || fe_set_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flg_q <= '{tx_rdy: 1'b1, tx_empty: 1'b1, rx_rdy: 1'b0, syn_det: 1'b0,
                       pe: 1'b0, oe: 1'b0, fe: 1'b0};
        end else begin
            flg_q <= flg_d;
        end
    end

    always_comb begin
        status_o             = '0;
        status_o[ST_TXRDY]   = flg_q.tx_rdy && tx_en;
        status_o[ST_RXRDY]   = flg_q.rx_rdy;
        status_o[ST_TXEMPTY] = flg_q.tx_empty && tx_en;
        status_o[ST_PERR]    = flg_q.pe;
        status_o[ST_OERR]    = flg_q.oe;
        status_o[ST_FERR]    = flg_q.fe;
        status_o[ST_SYNDET]  = flg_q.syn_det;
        status_o[ST_DSR]     = dsr_s;
    end

endmodule

// File: rtl/usart_ctrl_seq.sv
module usart_ctrl_seq
    import usart_seq_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              tx_rdy_i,
    input  logic              tx_empty_i,
    input  logic              rx_rdy_i,
    input  logic              syn_det_i,
    input  logic              pe_set_i,
    input  logic              oe_set_i,
    input  logic              fe_set_i,
    input  logic              dsr_i,
    output logic [STAT_W-1:0] status_o,
    output logic              dtr_o,
    output logic              rts_o,
    output logic              tx_en_o,
    output logic              rx_en_o,
    output logic              err_clr_o,
    output logic              soft_rst_o,
    output logic              async_o,
    output logic              sync_o,
    output logic [DATA_W-1:0] mode_o,
    output logic [DATA_W-1:0] sync_first_o,
    output logic [DATA_W-1:0] sync_last_o
);

    logic ctl_wr;
    logic cmd_valid;
    logic clr_req;

    assign ctl_wr = wr_en && addr;

    usart_mode_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctl_wr       (ctl_wr),
        .wdata        (wdata),
        .cmd_valid    (cmd_valid),
        .async_o      (async_o),
        .sync_o       (sync_o),
        .mode_o       (mode_o),
        .sync_first_o (sync_first_o),
        .sync_last_o  (sync_last_o)
    );

    usart_cmd_regs #(.DATA_W(DATA_W)) u_cmd (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .wdata      (wdata),
        .clr_req    (clr_req),
        .tx_en_o    (tx_en_o),
        .rx_en_o    (rx_en_o),
        .dtr_o      (dtr_o),
        .rts_o      (rts_o),
        .err_clr_o  (err_clr_o),
        .soft_rst_o (soft_rst_o)
    );

    usart_status_asm #(.SYNC_STAGES(SYNC_STAGES)) u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_rdy_i   (tx_rdy_i),
        .tx_empty_i (tx_empty_i),
        .rx_rdy_i   (rx_rdy_i),
        .syn_det_i  (syn_det_i),
        .pe_set_i   (pe_set_i),
        .oe_set_i   (oe_set_i),
        .fe_set_i   (fe_set_i),
        .clr_req    (clr_req),
        .tx_en      (tx_en_o),
        .dsr_i      (dsr_i),
        .status_o   (status_o)
    );

endmodule

// File: rtl/usart_ctrl_seq_chk.sv
module usart_ctrl_seq_chk
    import usart_seq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              addr,
    input logic [DATA_W-1:0] wdata,
    input logic [STAT_W-1:0] status_o,
    input logic              dtr_o,
    input logic              rts_o,
    input logic              tx_en_o,
    input logic              rx_en_o,
    input logic              err_clr_o,
    input logic              soft_rst_o,
    input logic              async_o,
    input logic              sync_o,
    input logic [DATA_W-1:0] mode_o
);

    logic run;
    assign run = async_o || sync_o;

    p_run_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(async_o && sync_o));

    p_mode_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr && !run && (wdata[1:0] != 2'b00) && !$past(wr_en && addr))
        |=> (async_o && mode_o == $past(wdata)));

    p_cmd_fields_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr && run && !wdata[CMD_SRST]) |=>
        (tx_en_o == $past(wdata[CMD_TXEN]) && dtr_o == $past(wdata[CMD_DTR]) &&
         rx_en_o == $past(wdata[CMD_RXEN]) && rts_o == $past(wdata[CMD_RTS])));

    p_err_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr && run && !wdata[CMD_SRST] && wdata[CMD_ECLR]) |=> err_clr_o);

    p_soft_rst_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr && run && wdata[CMD_SRST]) |=>
        (soft_rst_o && !run && !err_clr_o && $stable({dtr_o, rts_o, tx_en_o, rx_en_o})));

    p_data_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr) |=>
        $stable({dtr_o, rts_o, tx_en_o, rx_en_o, async_o, sync_o, mode_o}));

    p_pulses_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr_o || soft_rst_o) |-> $past(wr_en && addr));

    p_tx_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en_o |-> (!status_o[ST_TXRDY] && !status_o[ST_TXEMPTY]));

endmodule

bind usart_ctrl_seq usart_ctrl_seq_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .addr       (addr),
    .wdata      (wdata),
    .status_o   (status_o),
    .dtr_o      (dtr_o),
    .rts_o      (rts_o),
    .tx_en_o    (tx_en_o),
    .rx_en_o    (rx_en_o),
    .err_clr_o  (err_clr_o),
    .soft_rst_o (soft_rst_o),
    .async_o    (async_o),
    .sync_o     (sync_o),
    .mode_o     (mode_o)
);

// File: tb/usart_ctrl_seq_tb.sv
module usart_ctrl_seq_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       addr = 1'b0;
    logic [7:0] wdata = '0;
    logic       tx_rdy_i = 1'b0, tx_empty_i = 1'b0, rx_rdy_i = 1'b0, syn_det_i = 1'b0;
    logic       pe_set_i = 1'b0, oe_set_i = 1'b0, fe_set_i = 1'b0, dsr_i = 1'b1;
    logic [7:0] status_o, mode_o, sync_first_o, sync_last_o;
    logic       dtr_o, rts_o, tx_en_o, rx_en_o, err_clr_o, soft_rst_o, async_o, sync_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    usart_ctrl_seq u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .tx_rdy_i(tx_rdy_i), .tx_empty_i(tx_empty_i), .rx_rdy_i(rx_rdy_i),
        .syn_det_i(syn_det_i), .pe_set_i(pe_set_i), .oe_set_i(oe_set_i),
        .fe_set_i(fe_set_i), .dsr_i(dsr_i), .status_o(status_o), .dtr_o(dtr_o),
        .rts_o(rts_o), .tx_en_o(tx_en_o), .rx_en_o(rx_en_o), .err_clr_o(err_clr_o),
        .soft_rst_o(soft_rst_o), .async_o(async_o), .sync_o(sync_o), .mode_o(mode_o),
        .sync_first_o(sync_first_o), .sync_last_o(sync_last_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; addr = 1'b0; wdata = '0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // packs the control outputs {dtr, rts, tx_en, rx_en}
    function automatic logic [3:0] ctl4();
        return {dtr_o, rts_o, tx_en_o, rx_en_o};
    endfunction

    task automatic t_reset();
        tx_rdy_i = 1'b0; tx_empty_i = 1'b0; dsr_i = 1'b1;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        chk("R1 status in reset", status_o, 8'h85);
        chk("R1 controls in reset", {ctl4(), err_clr_o, soft_rst_o, async_o, sync_o}, 8'b0011_0000);
        chk("R11 dsr kept in reset", status_o[7], 1'b1);
        tx_rdy_i = 1'b1; tx_empty_i = 1'b1;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 first cycle after reset", {ctl4(), async_o, sync_o}, 6'b0011_00);
    endtask

    task automatic t_async_and_cmds();
        do_reset();
        wr(1'b1, 8'h4E);
        chk("R2 async entered", {async_o, sync_o}, 2'b10);
        chk("R2 mode captured", mode_o, 8'h4E);
        wr(1'b1, 8'h0A);
        chk("R5 cmd 0A", ctl4(), 4'b1100);
        chk("R10 tx flags masked", status_o & 8'h05, 8'h00);
        wr(1'b1, 8'h05);
        chk("R5 cmd 05", ctl4(), 4'b0011);
        chk("R10 tx flags visible again", status_o & 8'h05, 8'h05);
    endtask

    task automatic t_errors();
        pe_set_i = 1'b1; oe_set_i = 1'b1; fe_set_i = 1'b1;
        @(negedge clk);
        pe_set_i = 1'b0; oe_set_i = 1'b0; fe_set_i = 1'b0;
        chk("R9 errors set", status_o[5:3], 3'b111);
        @(negedge clk);
        chk("R9 errors sticky", status_o[5:3], 3'b111);
        wr(1'b1, 8'h15);
        chk("R6 clear pulse", err_clr_o, 1'b1);
        chk("R6 errors cleared", status_o[5:3], 3'b000);
        @(negedge clk);
        chk("R6 pulse one cycle", err_clr_o, 1'b0);
        pe_set_i = 1'b1;
        wr(1'b1, 8'h15);
        pe_set_i = 1'b0;
        chk("R6 set wins over clear", status_o[5:3], 3'b001);
    endtask

    task automatic t_soft_reset();
        wr(1'b1, 8'h05);
        wr(1'b1, 8'h5A);
        chk("R7 back to cleared", {async_o, sync_o}, 2'b00);
        chk("R7 soft reset pulse", soft_rst_o, 1'b1);
        chk("R7 rest of byte ignored", {ctl4(), err_clr_o}, 5'b0011_0);
        chk("R7 errors untouched", status_o[3], 1'b1);
        @(negedge clk);
        chk("R7 pulse one cycle", soft_rst_o, 1'b0);
        wr(1'b1, 8'h02);
        chk("R8 cleared-state write not a command", {ctl4(), async_o}, 5'b0011_1);
        wr(1'b0, 8'hFF);
        chk("R8 data write ignored", {ctl4(), async_o, sync_o, mode_o}, {6'b0011_10, 8'h02});
    endtask

    task automatic t_one_sync();
        do_reset();
        wr(1'b1, 8'h80);
        chk("R3 hunting after mode", {async_o, sync_o}, 2'b00);
        wr(1'b1, 8'h1A);
        chk("R3 sync run", {async_o, sync_o}, 2'b01);
        chk("R3 char stored", sync_last_o, 8'h1A);
        chk("R8 sync char not a command", {ctl4(), err_clr_o}, 5'b0011_0);
        wr(1'b1, 8'h02);
        chk("R5 command in sync run", ctl4(), 4'b1000);
    endtask

    task automatic t_two_sync();
        do_reset();
        wr(1'b1, 8'h0C);
        wr(1'b1, 8'h5A);
        chk("R4 still hunting", {async_o, sync_o}, 2'b00);
        chk("R4 first char", sync_first_o, 8'h5A);
        chk("R8 hunting write not a command", {ctl4(), err_clr_o, soft_rst_o}, 6'b0011_00);
        wr(1'b1, 8'h55);
        chk("R4 sync run", {async_o, sync_o}, 2'b01);
        chk("R4 last char", sync_last_o, 8'h55);
        chk("R4 mode kept", mode_o, 8'h0C);
    endtask

    task automatic t_status_and_dsr();
        tx_rdy_i = 1'b0; tx_empty_i = 1'b1; rx_rdy_i = 1'b1; syn_det_i = 1'b1;
        @(negedge clk);
        chk("R9 flag layout", status_o[6:0], 7'h46);
        dsr_i = 1'b0;
        @(negedge clk);
        chk("R11 dsr after one edge", status_o[7], 1'b1);
        @(negedge clk);
        chk("R11 dsr after two edges", status_o[7], 1'b0);
        tx_rdy_i = 1'b1; rx_rdy_i = 1'b0; syn_det_i = 1'b0;
        @(negedge clk);
        chk("R9 flags follow inputs", status_o[6:0], 7'h05);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_async_and_cmds();
        t_errors();
        t_soft_reset();
        t_one_sync();
        t_two_sync();
        t_status_and_dsr();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule